// File: doc/BRIEF.md
# Serial Register Access Slave for a Metering Core

This block is the device-side serial port of a metering chip. Four pins are sampled by the measurement clock: an active-low select, a sync pin that picks the mode, a serial clock and serial data. Data is split into an input, an output and an output enable. While select is high, an active-low pulse on sync that lasts long enough copies a bank of measurement records from a parallel input bus into local holding latches. While select is low, sync high puts the port in read mode. The port then drives the held records out one after another in a fixed order with no addressing. Sync low puts the port in write mode, where the host sends one-byte commands that set or clear single configuration bits.

Records are 32 bits and are grouped in fours. A read starts at the first record of the current group. A special all-ones command byte moves the group pointer on by one, so the host can skip earlier records. The configuration bank is visible on a parallel output. Two of its bits control the port itself: serial clock polarity and bit order within a byte.

The controller is a four-state machine. The states are IDLE, LATCH (select high, sync low), READ and WRITE. The transitions are:
- IDLE→LATCH on sync low.
- IDLE/LATCH→READ or WRITE on select low, chosen by sync.
- READ↔WRITE when sync toggles under select.
- Any state→IDLE or LATCH on select high.
- LATCH→IDLE on sync high.

Top module: `meter_serial_port`

## Requirements
- R1: After reset the data output enable is low and every configuration bit reads 0.
- R2: With select low, sync high enables the data output (read mode) and sync low releases it (write mode).
- R3: A sync low pulse while select is high copies the record bus into the holding latches only when sync is sampled low for at least LATCH_CYC+1 clock cycles (4 by default). A one-cycle pulse copies nothing.
- R4: A write command is 8 bits, most significant first: the value bit, then a 7-bit bit address. Data is sampled on the leading serial clock edge, and the eighth leading edge commits the write. For example, 0xAF sets bit 47 and 0x2F clears it.
- R5: Several commands may be sent within one select period. The bit count restarts after each eighth bit.
- R6: A read record takes 32 serial clocks. Its least significant byte goes out first, and each byte goes out most significant bit first by default. Bit 0 is valid before the first leading edge, and the output advances on each trailing edge.
- R7: Configuration bit 125 set to 1 sends each byte least significant bit first.
- R8: A read starts at record 4×group. It continues through the records in order and wraps from record 27 to record 0.
- R9: Command 0xFF advances the group pointer by one and wraps from group 6 to group 0. It changes no configuration bit.
- R10: A latch copy returns the group pointer to group 0.
- R11: Reading again without a new latch copy returns the same values, even when the record bus has changed.
- R12: Configuration bit 126 selects clock polarity. With 0 the clock idles high and the leading edge is falling. With 1 it idles low and the leading edge is rising.
- R13: Raising select aborts a partial command. If select rises in the same sampled cycle as the eighth leading edge, the abort wins and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low transfer select |
| sync_i | input | 1 | Mode pin: read when high under select; latch strobe when low while deselected |
| sclk | input | 1 | Serial clock from the host |
| sd_in | input | 1 | Serial data from the host (write mode) |
| rec_in | input | NREC*32 | Record bus; record k occupies bits [32k+31:32k] |
| sd_out | output | 1 | Serial data to the host |
| sd_oe | output | 1 | High while the port drives serial data |
| cfg_bits | output | 127 | Configuration bank; bit n is written by address n |

## Verification
Two pairs of functions can fall in the same sampled cycle.

The first pair is the commit on the eighth leading edge and an abort by select. The bench moves the last leading edge and the rise of select in the same instant, so both pass through the same synchroniser stages. It then judges that the addressed configuration bit stayed clear. The checker confirms that no output is driven in the cycle after select is seen high.

The second pair is a precharge commit and a configuration write, which share one decoder. The bench checks that a run of all-ones bytes leaves the whole configuration bank unchanged while the next read moves to the following group, including the wrap from group 6 to group 0.

// File: rtl/msp_pkg.sv
package msp_pkg;
    localparam int ADDR_W = 7;
    localparam int REC_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LATCH = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } msp_state_e;
endpackage

// File: rtl/msp_pin_sync.sv
module msp_pin_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[i] <= INIT[i];
                q[i]      <= INIT[i];
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/msp_cmd_unit.sv
module msp_cmd_unit
    import msp_pkg::*;
#(
    parameter int CFG_W = (1 << ADDR_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic             lead,
    input  logic             bit_in,
    output logic [CFG_W-1:0] cfg_q,
    output logic             prechg
);
    localparam int CMD_W = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] PRE_ADDR = '1;

    logic [CMD_W-2:0]         shreg;
    logic [$clog2(CMD_W)-1:0] wcnt;
    logic [CMD_W-1:0]         full_cmd;

    assign full_cmd = {shreg, bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            wcnt   <= '0;
            cfg_q  <= '0;
            prechg <= 1'b0;
        end else begin
            prechg <= 1'b0;
            if (restart || !active) begin
                wcnt <= '0;
            end else if (lead) begin
                if (wcnt == CMD_W - 1) begin
                    wcnt <= '0;
                    if (full_cmd[ADDR_W-1:0] == PRE_ADDR) begin
                        prechg <= full_cmd[CMD_W-1];
                    end else begin
                        cfg_q[full_cmd[ADDR_W-1:0]] <= full_cmd[CMD_W-1];
                    end
                end else begin
                    wcnt  <= wcnt + 1'b1;
                    shreg <= {shreg[CMD_W-3:0], bit_in};
                end
            end
        end
    end
endmodule

// File: rtl/msp_rec_unit.sv
module msp_rec_unit
    import msp_pkg::*;
#(
    parameter int GROUPS  = 7,
    parameter int PER_GRP = 4,
    parameter int NREC    = GROUPS * PER_GRP,
    parameter int GRP_W   = $clog2(GROUPS),
    parameter int PTR_W   = $clog2(NREC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [NREC*REC_W-1:0] rec_bus,
    input  logic                  prechg,
    input  logic                  start,
    input  logic                  advance,
    input  logic                  lsb_first,
    output logic                  bit_out,
    output logic [GRP_W-1:0]      grp,
    output logic [PTR_W-1:0]      rec_ptr
);
    localparam int BIT_W = $clog2(REC_W);

    logic [REC_W-1:0] hold [NREC];
    logic [BIT_W-1:0] bcnt;
    logic [2:0]       in_byte;
    logic [BIT_W-1:0] pos;

    for (genvar k = 0; k < NREC; k++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold[k] <= '0;
            end else if (capture) begin
                hold[k] <= rec_bus[k*REC_W +: REC_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp <= '0;
        end else if (capture) begin
            grp <= '0;
        end else if (prechg) begin
            grp <= (grp == GRP_W'(GROUPS - 1)) ? '0 : grp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt    <= '0;
            rec_ptr <= '0;
        end else if (start) begin
            bcnt    <= '0;
            rec_ptr <= PTR_W'(grp) * PTR_W'(PER_GRP);
        end else if (advance) begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == BIT_W'(REC_W - 1)) begin
                rec_ptr <= (rec_ptr == PTR_W'(NREC - 1)) ? '0 : rec_ptr + 1'b1;
            end
        end
    end

    assign in_byte = lsb_first ? bcnt[2:0] : ~bcnt[2:0];
    assign pos     = {bcnt[BIT_W-1:3], in_byte};
    assign bit_out = hold[rec_ptr][pos];
endmodule

// File: rtl/meter_serial_port.sv
module meter_serial_port
    import msp_pkg::*;
#(
    parameter int GROUPS    = 7,
    parameter int PER_GRP   = 4,
    parameter int LATCH_CYC = 3,
    parameter int POL_IDX   = 126,
    parameter int LSBF_IDX  = 125,
    parameter int NREC      = GROUPS * PER_GRP,
    parameter int CFG_W     = (1 << ADDR_W) - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_n,
    input  logic                  sync_i,
    input  logic                  sclk,
    input  logic                  sd_in,
    input  logic [NREC*REC_W-1:0] rec_in,
    output logic                  sd_out,
    output logic                  sd_oe,
    output logic [CFG_W-1:0]      cfg_bits
);
    localparam int GRP_W = $clog2(GROUPS);
    localparam int PTR_W = $clog2(NREC);
    localparam int LC_W  = $clog2(LATCH_CYC + 1);

    logic [3:0] pins_q;
    logic s_sel, s_syn, s_clk, s_din, s_clk_d;
    logic pol, lead, trail;

    msp_state_e state, state_nx;
    logic [LC_W-1:0] lcnt;
    logic latch_fire, rd_start, rd_act, wr_restart, wr_act;

    logic             prechg;
    logic             rd_bit;
    logic [GRP_W-1:0] grp;
    logic [PTR_W-1:0] rec_ptr;

    msp_pin_sync #(.W(4), .INIT(4'b1111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, sync_i, sclk, sd_in}),
        .q     (pins_q)
    );
    assign {s_sel, s_syn, s_clk, s_din} = pins_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_clk_d <= 1'b1;
        else        s_clk_d <= s_clk;
    end

    assign pol   = cfg_bits[POL_IDX];
    assign lead  = (s_clk != s_clk_d) && (s_clk == pol);
    assign trail = (s_clk != s_clk_d) && (s_clk != pol);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lcnt  <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_LATCH && !s_syn) begin
                if (lcnt != LC_W'(LATCH_CYC)) lcnt <= lcnt + 1'b1;
            end else begin
                lcnt <= '0;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!s_sel)      state_nx = s_syn ? ST_READ : ST_WRITE;
                else if (!s_syn) state_nx = ST_LATCH;
            end
            ST_LATCH: begin
                if (!s_sel)     state_nx = s_syn ? ST_READ : ST_WRITE;
                else if (s_syn) state_nx = ST_IDLE;
            end
            ST_READ: begin
                if (s_sel)       state_nx = s_syn ? ST_IDLE : ST_LATCH;
                else if (!s_syn) state_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (s_sel)      state_nx = s_syn ? ST_IDLE : ST_LATCH;
                else if (s_syn) state_nx = ST_READ;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        latch_fire = (state == ST_LATCH) && s_sel && !s_syn &&
                     (lcnt == LC_W'(LATCH_CYC - 1));
        rd_start   = (state_nx == ST_READ) && (state != ST_READ);
        rd_act     = (state == ST_READ) && !s_sel && s_syn;
        wr_restart = (state_nx == ST_WRITE) && (state != ST_WRITE);
        wr_act     = (state == ST_WRITE) && !s_sel && !s_syn;
        sd_oe      = (state == ST_READ);
        sd_out     = (state == ST_READ) ? rd_bit : 1'b1;
    end

    msp_cmd_unit #(.CFG_W(CFG_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_restart),
        .active  (wr_act),
        .lead    (lead),
        .bit_in  (s_din),
        .cfg_q   (cfg_bits),
        .prechg  (prechg)
    );

    msp_rec_unit #(.GROUPS(GROUPS), .PER_GRP(PER_GRP), .NREC(NREC)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (latch_fire),
        .rec_bus   (rec_in),
        .prechg    (prechg),
        .start     (rd_start),
        .advance   (rd_act && trail),
        .lsb_first (cfg_bits[LSBF_IDX]),
        .bit_out   (rd_bit),
        .grp       (grp),
        .rec_ptr   (rec_ptr)
    );
endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
    parameter int GROUPS = 7,
    parameter int NREC   = 28,
    parameter int CFG_W  = 127,
    parameter int GRP_W  = 3,
    parameter int PTR_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_sel,
    input logic             s_syn,
    input logic             sd_oe,
    input logic             latch_fire,
    input logic             prechg,
    input logic [GRP_W-1:0] grp,
    input logic [PTR_W-1:0] rec_ptr,
    input logic [CFG_W-1:0] cfg_bits
);
    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        s_sel |=> !sd_oe); // R13
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_sel && s_syn) |=> sd_oe); // R2
    AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_sel && !s_syn) |=> !sd_oe); // R2
    AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        grp < GRP_W'(GROUPS)); // R9
    AST_REC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ptr < PTR_W'(NREC)); // R8
    AST_LATCH_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        latch_fire |=> grp == '0); // R10
    AST_PRECHG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        prechg |=> grp == (($past(grp) == GRP_W'(GROUPS - 1)) ? '0 : $past(grp) + 1'b1)); // R9
    AST_PRECHG_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        prechg |-> $stable(cfg_bits)); // R9
endmodule

bind meter_serial_port msp_checker #(
    .GROUPS (GROUPS),
    .NREC   (NREC),
    .CFG_W  (CFG_W),
    .GRP_W  (GRP_W),
    .PTR_W  (PTR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_sel      (s_sel),
    .s_syn      (s_syn),
    .sd_oe      (sd_oe),
    .latch_fire (latch_fire),
    .prechg     (prechg),
    .grp        (grp),
    .rec_ptr    (rec_ptr),
    .cfg_bits   (cfg_bits)
);

// File: tb/tb_meter_serial_port.sv
module tb_meter_serial_port;
    localparam int NREC  = 28;
    localparam int CFG_W = 127;
    localparam int H     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sync_i = 1'b1, sclk = 1'b1, sd_in = 1'b1;
    logic [NREC*32-1:0] rec_in = '0;
    logic sd_out, sd_oe;
    logic [CFG_W-1:0] cfg_bits;

    logic [CFG_W-1:0] exp_cfg = '0;
    logic pol = 1'b0;
    logic lsbf = 1'b0;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    meter_serial_port dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sync_i(sync_i), .sclk(sclk),
        .sd_in(sd_in), .rec_in(rec_in), .sd_out(sd_out), .sd_oe(sd_oe),
        .cfg_bits(cfg_bits)
    );

    // {command, bit index, expected value}
    localparam logic [15:0] WTAB [6] = '{
        {8'hAF, 7'd47,  1'b1},
        {8'h85, 7'd5,   1'b1},
        {8'h05, 7'd5,   1'b0},
        {8'h80, 7'd0,   1'b1},
        {8'hFC, 7'd124, 1'b1},
        {8'h2F, 7'd47,  1'b0}
    };

    function automatic logic [31:0] word(int i, logic [31:0] s);
        return s ^ (32'h0103_0507 * (i + 1)) ^ {i[7:0], 24'h0};
    endfunction

    task automatic fill(logic [31:0] s);
        for (int i = 0; i < NREC; i++) rec_in[i*32 +: 32] = word(i, s);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(logic b);
        sd_in = b; step(H);
        sclk = pol; step(H);
        sclk = ~pol; step(H);
    endtask

    task automatic put_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
    endtask

    task automatic model_cmd(logic [7:0] b);
        if (b[6:0] != 7'h7F) exp_cfg[b[6:0]] = b[7];
    endtask

    task automatic wr_begin();
        sel_n = 1'b0; step(H);
        sync_i = 1'b0; step(H);
    endtask

    task automatic wr_end();
        sel_n = 1'b1; sync_i = 1'b1; step(H);
    endtask

    task automatic wr_cmd(logic [7:0] b);
        wr_begin(); put_byte(b); wr_end(); model_cmd(b);
    endtask

    task automatic latch_long();
        sync_i = 1'b0; step(10);
        sync_i = 1'b1; step(H);
    endtask

    task automatic read_word(output logic [31:0] v);
        for (int i = 0; i < 32; i++) begin
            if (lsbf) v[(i/8)*8 + (i%8)] = sd_out;
            else      v[(i/8)*8 + 7 - (i%8)] = sd_out;
            sclk = pol; step(H);
            sclk = ~pol; step(H);
        end
    endtask

    task automatic rd_begin(); sel_n = 1'b0; step(H); endtask
    task automatic rd_end();   sel_n = 1'b1; step(H); endtask

    task automatic prechg_read(int n, output logic [31:0] v);
        wr_begin();
        repeat (n) put_byte(8'hFF);
        sync_i = 1'b1; step(H);
        read_word(v);
        rd_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] sa = 32'hA5C3_1E00;
        logic [31:0] sb = 32'h3C96_E700;
        step(4);
        rst_n = 1'b1;
        step(4);

        // R1 reset state
        check("R1 oe", sd_oe, 1'b0);
        check("R1 cfg", cfg_bits, '0);

        // R4 table of single-bit writes
        foreach (WTAB[k]) begin
            wr_cmd(WTAB[k][15:8]);
            check("R4 bit", cfg_bits[WTAB[k][7:1]], WTAB[k][0]);
        end
        check("R4 bank", cfg_bits, exp_cfg);

        // R5 two commands in one select period
        wr_begin(); put_byte(8'h81); put_byte(8'h82); wr_end();
        model_cmd(8'h81); model_cmd(8'h82);
        check("R5 bank", cfg_bits, exp_cfg);

        // R2 mode selection
        sel_n = 1'b0; step(H);
        check("R2 read oe", sd_oe, 1'b1);
        sync_i = 1'b0; step(H);
        check("R2 write oe", sd_oe, 1'b0);
        wr_end();

        // R3 R6 R8 latch and read group 0
        fill(sa); latch_long();
        rd_begin();
        for (int i = 0; i < 4; i++) begin
            read_word(v);
            check("R6 R8 rec", v, word(i, sa));
        end
        rd_end();

        // R11 R3 short pulse ignored, reread same data
        fill(sb);
        sync_i = 1'b0; step(1); sync_i = 1'b1; step(H);
        rd_begin(); read_word(v); rd_end();
        check("R11 R3 reread", v, word(0, sa));

        // R9 precharge
        prechg_read(1, v);
        check("R9 grp1", v, word(4, sa));
        check("R9 cfg kept", cfg_bits, exp_cfg);
        prechg_read(6, v);
        check("R9 wrap", v, word(0, sa));

        // R8 wrap at record 27
        wr_begin();
        repeat (6) put_byte(8'hFF);
        sync_i = 1'b1; step(H);
        for (int i = 24; i < 29; i++) begin
            read_word(v);
            check("R8 seq", v, word(i % NREC, sa));
        end
        rd_end();

        // R10 R3 long latch resets group and takes new data
        latch_long();
        rd_begin(); read_word(v); rd_end();
        check("R10 R3 new", v, word(0, sb));

        // R7 lsb-first
        wr_cmd(8'hFD); lsbf = 1'b1;
        rd_begin(); read_word(v); rd_end();
        check("R7 lsbf", v, word(0, sb));
        wr_cmd(8'h7D); lsbf = 1'b0;

        // R13 abort of partial command
        wr_begin();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
        wr_end();
        wr_cmd(8'h84);
        check("R13 abort", cfg_bits, exp_cfg);

        // R13 commit edge and deselect in the same cycle
        wr_begin();
        for (int i = 7; i >= 1; i--) put_bit(8'h86 >> i);
        sd_in = 1'b0; step(H);
        sclk = pol; sel_n = 1'b1; sync_i = 1'b1; step(H);
        sclk = ~pol; step(H);
        check("R13 same cycle", cfg_bits[6], 1'b0);

        // R12 clock polarity
        wr_cmd(8'hFE);
        pol = 1'b1; sclk = 1'b0; step(H);
        check("R12 pol bit", cfg_bits[126], 1'b1);
        rd_begin(); read_word(v); rd_end();
        check("R12 read", v, word(0, sb));
        wr_cmd(8'h88);
        check("R12 write", cfg_bits, exp_cfg);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule